// File: doc/BRIEF.md
# Flash Bank Status and Interrupt Recorder

This block keeps one status record per flash bank for a multi-bank flash controller. When the dispatch logic hands a command to a bank, the recorder copies the command description into that bank's snapshot area. Firmware can later read back which command each bank last received. Each bank also owns a sticky interrupt byte. The bank engines raise event pulses, one vector per kind of event with one bit per bank, and the recorder ORs the matching flag codes into that bank's byte. Each bank also has a byte that mirrors the state of its engine's state machine, where zero means the bank is idle.

Firmware reads all records over a byte-wide register bus with a one-cycle read latency. It clears interrupt flags by writing ones to them. A single summary interrupt output stays high while any flag of any bank is set. The map is contiguous. The snapshot areas come first, one per bank, each `SNAP_BYTES` long (48 by default). The interrupt bytes follow at `INTR_BASE = NUM_BANKS*SNAP_BYTES + bank`. The state bytes come after them at `FSM_BASE = INTR_BASE + NUM_BANKS + bank`.

Top module: `bank_status_rec`

## Requirements
- R1: While reset is asserted, every snapshot byte, interrupt byte and state byte is zero, `irq` is low and `reg_rvalid` is low.
- R2: On a cycle with `disp_valid` and `disp_ready` both high and `disp_bank` below `NUM_BANKS`, byte k of `disp_info` (bits 8k+7..8k) becomes readable at address `disp_bank*SNAP_BYTES + k`. The snapshots of all other banks stay unchanged.
- R3: A dispatch without the full handshake (valid without ready, or ready without valid), or one that names a bank number of `NUM_BANKS` or above, changes no snapshot.
- R4: A pulse on one event input sets that bank's interrupt byte as follows: corrected 0x01, CRC fail 0x02, mismatch 0x04, bad block low chip 0x08, bad block high chip 0x10, all-0xFF 0x20, ECC fail 0x80. Bit 6 is never set.
- R5: A pulse on the data-corrupt input sets 0x82, which is the ECC-fail and CRC-fail bits together.
- R6: Interrupt bits stay set across any number of cycles and further pulses until firmware clears them.
- R7: A write to `INTR_BASE + b` clears exactly those bits of bank b's interrupt byte that are 1 in `reg_wdata`. All other bits stay as they were.
- R8: If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R9: Byte b of `fsm_in` is registered every cycle and can be read at `FSM_BASE + b`. Zero means idle.
- R10: Writes to snapshot addresses, state addresses or unmapped addresses change no readable byte.
- R11: `reg_rvalid` is high exactly one cycle after each cycle with `reg_rd` high, and `reg_rdata` then holds the byte at the requested address. Unmapped addresses read as zero.
- R12: `irq` is high in exactly those cycles in which at least one bit of any bank's interrupt byte is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | The dispatcher offers a command |
| disp_ready | input | 1 | The target bank accepts the command |
| disp_bank | input | BANK_W | Target bank number |
| disp_info | input | SNAP_BYTES*8 | Command description, byte k in bits 8k+7..8k |
| fsm_in | input | NUM_BANKS*8 | Engine state byte per bank |
| ev_corrected | input | NUM_BANKS | Corrected-error pulse per bank |
| ev_crc_fail | input | NUM_BANKS | CRC failure pulse per bank |
| ev_mismatch | input | NUM_BANKS | Compare mismatch pulse per bank |
| ev_badblk_lo | input | NUM_BANKS | Bad block on the low chip, per bank |
| ev_badblk_hi | input | NUM_BANKS | Bad block on the high chip, per bank |
| ev_all_ff | input | NUM_BANKS | Page read back as all 0xFF, per bank |
| ev_ecc_fail | input | NUM_BANKS | Uncorrectable ECC pulse per bank |
| ev_corrupt | input | NUM_BANKS | Data corrupt pulse per bank |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 8 | Write data (write-one-to-clear mask) |
| reg_rdata | output | 8 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| irq | output | 1 | Summary interrupt |

## Verification
The bench sweeps the whole byte map, including the region edges and the addresses past the end of the map. A design that misplaces the bank stride or the region bases would show a byte at the wrong address. The bench pulses every event kind on every bank and checks the exact flag code. A swapped bit, or a data-corrupt code that sets only one bit, would give a wrong byte. It drives the set and the clear of one bit in the same cycle, where a design that lets the clear win would read back 0x00. It also drives dispatches that lack ready or that name an out-of-range bank, where a design that ignores the handshake would overwrite a snapshot.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  // Interrupt flag codes; bit 6 is unused.
  localparam logic [7:0] FLAG_CORRECTED = 8'h01;
  localparam logic [7:0] FLAG_CRC       = 8'h02;
  localparam logic [7:0] FLAG_MISMATCH  = 8'h04;
  localparam logic [7:0] FLAG_BADBLK_LO = 8'h08;
  localparam logic [7:0] FLAG_BADBLK_HI = 8'h10;
  localparam logic [7:0] FLAG_ALL_FF    = 8'h20;
  localparam logic [7:0] FLAG_ECC       = 8'h80;
  localparam logic [7:0] FLAG_CORRUPT   = FLAG_ECC | FLAG_CRC;

  // Builds the set mask for one bank from its event pulses.
  function automatic logic [7:0] event_mask(
    input logic corr, input logic crc, input logic mism, input logic blo,
    input logic bhi, input logic aff, input logic ecc, input logic corrupt);
    logic [7:0] m;
    m = '0;
    if (corr)    m = m | FLAG_CORRECTED;
    if (crc)     m = m | FLAG_CRC;
    if (mism)    m = m | FLAG_MISMATCH;
    if (blo)     m = m | FLAG_BADBLK_LO;
    if (bhi)     m = m | FLAG_BADBLK_HI;
    if (aff)     m = m | FLAG_ALL_FF;
    if (ecc)     m = m | FLAG_ECC;
    if (corrupt) m = m | FLAG_CORRUPT;
    return m;
  endfunction

  // The clear is applied first and the set after it, so a set wins.
  function automatic logic [7:0] sticky_next(
    input logic [7:0] cur, input logic [7:0] clr, input logic [7:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/bsr_bank_slot.sv
module bsr_bank_slot #(
  parameter int SNAP_BYTES = 48
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              set_mask,
  input  logic [7:0]              clr_mask,
  input  logic                    snap_we,
  input  logic [SNAP_BYTES*8-1:0] snap_din,
  input  logic [7:0]              fsm_din,
  output logic [7:0]              intr_q,
  output logic [7:0]              fsm_q,
  output logic [SNAP_BYTES*8-1:0] snap_q
);
  import bsr_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intr_q <= '0;
      fsm_q  <= '0;
      snap_q <= '0;
    end else begin
      intr_q <= sticky_next(intr_q, clr_mask, set_mask);
      fsm_q  <= fsm_din;
      if (snap_we) snap_q <= snap_din;
    end
  end

endmodule

// File: rtl/bsr_read_port.sv
module bsr_read_port #(
  parameter int NUM_BANKS  = 8,
  parameter int SNAP_BYTES = 48,
  parameter int ADDR_W     = 10
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rd_en,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [NUM_BANKS*SNAP_BYTES*8-1:0] snap_flat,
  input  logic [NUM_BANKS*8-1:0]            intr_flat,
  input  logic [NUM_BANKS*8-1:0]            fsm_flat,
  output logic [7:0]                        rdata,
  output logic                              rvalid
);
  localparam int MAP_BYTES = NUM_BANKS * (SNAP_BYTES + 2);
  localparam logic [ADDR_W-1:0] MAP_END = ADDR_W'(MAP_BYTES);

  // The regions are contiguous, so byte index equals address.
  logic [MAP_BYTES*8-1:0] map_flat;
  logic [7:0]             rd_byte;

  assign map_flat = {fsm_flat, intr_flat, snap_flat};

  always_comb begin
    rd_byte = '0;
    if (addr < MAP_END) rd_byte = 8'(map_flat >> {addr, 3'b000});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_byte;
    end
  end

endmodule

// File: rtl/bank_status_rec.sv
module bank_status_rec #(
  parameter int NUM_BANKS  = 8,
  parameter int SNAP_BYTES = 48,
  parameter int BANK_W     = 5,
  parameter int ADDR_W     = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    disp_valid,
  input  logic                    disp_ready,
  input  logic [BANK_W-1:0]       disp_bank,
  input  logic [SNAP_BYTES*8-1:0] disp_info,
  input  logic [NUM_BANKS*8-1:0]  fsm_in,
  input  logic [NUM_BANKS-1:0]    ev_corrected,
  input  logic [NUM_BANKS-1:0]    ev_crc_fail,
  input  logic [NUM_BANKS-1:0]    ev_mismatch,
  input  logic [NUM_BANKS-1:0]    ev_badblk_lo,
  input  logic [NUM_BANKS-1:0]    ev_badblk_hi,
  input  logic [NUM_BANKS-1:0]    ev_all_ff,
  input  logic [NUM_BANKS-1:0]    ev_ecc_fail,
  input  logic [NUM_BANKS-1:0]    ev_corrupt,
  input  logic                    reg_rd,
  input  logic                    reg_wr,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [7:0]              reg_wdata,
  output logic [7:0]              reg_rdata,
  output logic                    reg_rvalid,
  output logic                    irq
);
  import bsr_pkg::*;

  localparam int INTR_BASE = NUM_BANKS * SNAP_BYTES;
  localparam int SNAP_W    = SNAP_BYTES * 8;

  // Named internal events, also observed by the checker.
  logic                           dispatch_fire;
  logic [NUM_BANKS-1:0]           snap_we;
  logic [NUM_BANKS*8-1:0]         set_flat;
  logic [NUM_BANKS*8-1:0]         clr_flat;
  logic [NUM_BANKS*8-1:0]         intr_flat;
  logic [NUM_BANKS*8-1:0]         fsm_flat;
  logic [NUM_BANKS*SNAP_W-1:0]    snap_flat;

  assign dispatch_fire = disp_valid && disp_ready;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(INTR_BASE + g);
    localparam logic [BANK_W-1:0] MY_BANK  = BANK_W'(g);

    assign snap_we[g] = dispatch_fire && (disp_bank == MY_BANK);
    assign set_flat[g*8 +: 8] = event_mask(ev_corrected[g], ev_crc_fail[g],
      ev_mismatch[g], ev_badblk_lo[g], ev_badblk_hi[g], ev_all_ff[g],
      ev_ecc_fail[g], ev_corrupt[g]);
    assign clr_flat[g*8 +: 8] = (reg_wr && reg_addr == CLR_ADDR) ? reg_wdata : 8'h00;

    bsr_bank_slot #(.SNAP_BYTES(SNAP_BYTES)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mask (set_flat[g*8 +: 8]),
      .clr_mask (clr_flat[g*8 +: 8]),
      .snap_we  (snap_we[g]),
      .snap_din (disp_info),
      .fsm_din  (fsm_in[g*8 +: 8]),
      .intr_q   (intr_flat[g*8 +: 8]),
      .fsm_q    (fsm_flat[g*8 +: 8]),
      .snap_q   (snap_flat[g*SNAP_W +: SNAP_W])
    );
  end

  bsr_read_port #(
    .NUM_BANKS  (NUM_BANKS),
    .SNAP_BYTES (SNAP_BYTES),
    .ADDR_W     (ADDR_W)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (reg_rd),
    .addr      (reg_addr),
    .snap_flat (snap_flat),
    .intr_flat (intr_flat),
    .fsm_flat  (fsm_flat),
    .rdata     (reg_rdata),
    .rvalid    (reg_rvalid)
  );

  assign irq = |intr_flat;

endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
  parameter int NB = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_rd,
  input logic          reg_rvalid,
  input logic          irq,
  input logic          disp_valid,
  input logic          disp_ready,
  input logic [NB-1:0] snap_we,
  input logic [NB*8-1:0] intr_flat,
  input logic [NB*8-1:0] set_flat,
  input logic [NB*8-1:0] clr_flat
);
  localparam logic [NB*8-1:0] BIT6_MASK = {NB{8'h40}};

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |-> (intr_flat == '0 && !irq && !reg_rvalid));

  assert_snap_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(snap_we));

  assert_snap_handshake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_we != '0) |-> (disp_valid && disp_ready));

  assert_no_bit6_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_flat & BIT6_MASK) == '0);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((intr_flat & $past(intr_flat) & ~$past(clr_flat)) ==
              ($past(intr_flat) & ~$past(clr_flat))));

  assert_clear_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(clr_flat) != '0));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flat != '0) |=> ((intr_flat & $past(set_flat)) == $past(set_flat)));

  assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  assert_read_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);

  assert_irq_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(set_flat) != '0));

endmodule

bind bank_status_rec bsr_checker #(.NB(NUM_BANKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_rd     (reg_rd),
  .reg_rvalid (reg_rvalid),
  .irq        (irq),
  .disp_valid (disp_valid),
  .disp_ready (disp_ready),
  .snap_we    (snap_we),
  .intr_flat  (intr_flat),
  .set_flat   (set_flat),
  .clr_flat   (clr_flat)
);

// File: tb/bank_status_rec_test.sv
module bank_status_rec_test;
  localparam int NB = 8;
  localparam int SB = 48;
  localparam int BW = 5;
  localparam int AW = 10;
  localparam int SNAP_END  = NB * SB;
  localparam int INTR_BASE = SNAP_END;
  localparam int FSM_BASE  = INTR_BASE + NB;
  localparam int MAP_END   = FSM_BASE + NB;

  logic clk = 1'b0;
  logic rst_n;
  logic disp_valid, disp_ready;
  logic [BW-1:0] disp_bank;
  logic [SB*8-1:0] disp_info;
  logic [NB*8-1:0] fsm_in;
  logic [NB-1:0] ev_corrected, ev_crc_fail, ev_mismatch, ev_badblk_lo;
  logic [NB-1:0] ev_badblk_hi, ev_all_ff, ev_ecc_fail, ev_corrupt;
  logic reg_rd, reg_wr;
  logic [AW-1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic reg_rvalid, irq;

  int nchk = 0;
  int nfail = 0;
  logic [7:0] exp_snap [SNAP_END];
  logic [7:0] exp_intr [NB];
  logic [7:0] exp_fsm  [NB];

  always #2.5 clk = ~clk;

  bank_status_rec #(.NUM_BANKS(NB), .SNAP_BYTES(SB), .BANK_W(BW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_bank(disp_bank), .disp_info(disp_info), .fsm_in(fsm_in),
    .ev_corrected(ev_corrected), .ev_crc_fail(ev_crc_fail), .ev_mismatch(ev_mismatch),
    .ev_badblk_lo(ev_badblk_lo), .ev_badblk_hi(ev_badblk_hi), .ev_all_ff(ev_all_ff),
    .ev_ecc_fail(ev_ecc_fail), .ev_corrupt(ev_corrupt), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .irq(irq));

  task automatic chk(input string req, input string what, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int a);
    if (a < SNAP_END) return exp_snap[a];
    if (a < FSM_BASE) return exp_intr[a - INTR_BASE];
    if (a < MAP_END)  return exp_fsm[a - FSM_BASE];
    return 8'h00;
  endfunction

  function automatic logic [7:0] flag_code(input int f);
    if (f < 6)  return 8'(1 << f);
    if (f == 6) return 8'h80;
    return 8'h82;
  endfunction

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1;
    reg_addr = AW'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
    if (!reg_rvalid) chk("R11", $sformatf("rvalid addr %0d", a), 0, 1);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_addr = AW'(a);
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_ev(input int f, input int b, input logic v);
    case (f)
      0: ev_corrected[b] = v;
      1: ev_crc_fail[b]  = v;
      2: ev_mismatch[b]  = v;
      3: ev_badblk_lo[b] = v;
      4: ev_badblk_hi[b] = v;
      5: ev_all_ff[b]    = v;
      6: ev_ecc_fail[b]  = v;
      default: ev_corrupt[b] = v;
    endcase
  endtask

  task automatic pulse(input int f, input int b);
    @(negedge clk);
    set_ev(f, b, 1'b1);
    @(negedge clk);
    set_ev(f, b, 1'b0);
  endtask

  task automatic disp(input int b, input int seed, input logic v, input logic r);
    @(negedge clk);
    for (int k = 0; k < SB; k++) disp_info[k*8 +: 8] = 8'((seed + k * 7 + b * 13) & 8'hFF);
    disp_bank = BW'(b);
    disp_valid = v;
    disp_ready = r;
    @(negedge clk);
    disp_valid = 1'b0;
    disp_ready = 1'b0;
    if (v && r && b < NB)
      for (int k = 0; k < SB; k++) exp_snap[b*SB + k] = 8'((seed + k * 7 + b * 13) & 8'hFF);
  endtask

  task automatic sweep(input string req);
    logic [7:0] d;
    for (int a = 0; a < MAP_END + 4; a++) begin
      rd(a, d);
      chk(req, $sformatf("addr %0d", a), int'(d), int'(exp_byte(a)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0;
    disp_valid = 0; disp_ready = 0; disp_bank = '0; disp_info = '0; fsm_in = '0;
    ev_corrected = '0; ev_crc_fail = '0; ev_mismatch = '0; ev_badblk_lo = '0;
    ev_badblk_hi = '0; ev_all_ff = '0; ev_ecc_fail = '0; ev_corrupt = '0;
    reg_rd = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    for (int i = 0; i < SNAP_END; i++) exp_snap[i] = '0;
    for (int b = 0; b < NB; b++) begin exp_intr[b] = '0; exp_fsm[b] = '0; end
    repeat (3) @(negedge clk);
    chk("R1", "irq in reset", int'(irq), 0);
    chk("R1", "rvalid in reset", int'(reg_rvalid), 0);
    rst_n = 1'b1;
    sweep("R1");

    // R2: one dispatch per bank, then an overwrite of bank 5
    for (int b = 0; b < NB; b++) disp(b, 8'h30, 1'b1, 1'b1);
    disp(5, 8'hC1, 1'b1, 1'b1);
    // R3: incomplete handshakes and an out-of-range bank
    disp(2, 8'h99, 1'b1, 1'b0);
    disp(3, 8'h77, 1'b0, 1'b1);
    disp(9, 8'h55, 1'b1, 1'b1);
    sweep("R2 R3");

    // R4 R5 R7 R12: every event kind on every bank
    for (int b = 0; b < NB; b++) begin
      for (int f = 0; f < 8; f++) begin
        pulse(f, b);
        chk("R12", "irq after event", int'(irq), 1);
        rd(INTR_BASE + b, d);
        chk(f == 7 ? "R5" : "R4", $sformatf("bank %0d kind %0d", b, f), int'(d), int'(flag_code(f)));
        wr(INTR_BASE + b, 8'hFF);
        rd(INTR_BASE + b, d);
        chk("R7", $sformatf("cleared bank %0d", b), int'(d), 0);
        chk("R12", "irq after clear", int'(irq), 0);
      end
    end

    // R6: flags accumulate and persist
    pulse(1, 1);
    pulse(2, 1);
    pulse(1, 1);
    repeat (10) @(negedge clk);
    rd(INTR_BASE + 1, d);
    chk("R6", "sticky bank 1", int'(d), 8'h06);
    // R7: partial clear
    wr(INTR_BASE + 1, 8'h02);
    rd(INTR_BASE + 1, d);
    chk("R7", "partial clear bank 1", int'(d), 8'h04);
    exp_intr[1] = 8'h04;
    chk("R12", "irq with pending bit", int'(irq), 1);

    // R8: set and clear in the same cycle
    pulse(2, 3);
    @(negedge clk);
    ev_crc_fail[3] = 1'b1;
    reg_wr = 1'b1;
    reg_addr = AW'(INTR_BASE + 3);
    reg_wdata = 8'hFF;
    @(negedge clk);
    ev_crc_fail[3] = 1'b0;
    reg_wr = 1'b0;
    rd(INTR_BASE + 3, d);
    chk("R8", "set beats clear", int'(d), 8'h02);
    exp_intr[3] = 8'h02;

    // R9: engine state mirror
    @(negedge clk);
    for (int b = 0; b < NB; b++) begin
      fsm_in[b*8 +: 8] = 8'(b * 8'h21 + 1);
      exp_fsm[b] = 8'(b * 8'h21 + 1);
    end
    for (int b = 0; b < NB; b++) begin
      rd(FSM_BASE + b, d);
      chk("R9", $sformatf("state bank %0d", b), int'(d), int'(exp_fsm[b]));
    end
    @(negedge clk);
    fsm_in[4*8 +: 8] = 8'h00;
    exp_fsm[4] = 8'h00;
    rd(FSM_BASE + 4, d);
    chk("R9", "bank 4 idle", int'(d), 0);

    // R10: writes outside the interrupt bytes are ignored
    wr(5, 8'h00);
    wr(SB + 1, 8'hFF);
    wr(FSM_BASE + 2, 8'h00);
    wr(MAP_END + 1, 8'hFF);
    sweep("R10 R11");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule